// File: doc/BRIEF.md
# DDR SDRAM Command Scheduler

This block sits between a memory controller's request logic and the command pins of a DDR SDRAM. The host offers one request at a time: open a row, read, write, close one bank, close all banks, refresh, or load the mode register. The block drives the matching chip-select, row-strobe, column-strobe, write-enable, bank and address pins. It keeps the open or closed state of each bank, and it holds a request on a valid/ready handshake until every row and command spacing rule is met. An illegal request is consumed at once and signalled by a one-cycle error pulse, and no command reaches the pins for it.

A refresh interval timer runs on its own. When it expires, host requests stall. If any bank is open, the block closes all banks, waits the precharge period and then issues an auto refresh. All spacing limits are parameters in clock cycles. The defaults suit a 7.5 ns clock: 3 cycles open-to-column, 3 cycles precharge, 6 cycles open-to-close, 9 cycles open-to-open on one bank, 2 cycles between opens of different banks, 10 cycles after refresh, 2 cycles after a mode load, and one refresh every 1040 cycles.

Top module: `ddr_cmd_sched`

## Requirements
- R1: After reset and in every cycle without a command, the pins show NOP (CS#,RAS#,CAS#,WE# = 0,1,1,1) with BA and address zero and err_o low. After reset all banks are closed and no spacing limit is pending.
- R2: A request is accepted in a cycle where req_valid_i and req_ready_o are both high, and its command appears on the registered pins in the next cycle. The op codes on req_op_i are 0 open row, 1 read, 2 write, 3 close bank, 4 close all, 5 refresh, 6 mode load and 7 undefined. The pin codes, in the order CS#,RAS#,CAS#,WE#, are 0011 open, 0101 read, 0100 write, 0010 close, 0001 refresh and 0000 mode load.
- R3: An open-row command carries req_addr_i on A and the bank on BA. Read and write carry req_addr_i[9:0] on A9..A0, req_ap_i on A10 and zero on A12..A11. Close-bank drives A10 low. Close-all drives A10 high with BA zero. Mode load drives req_addr_i on A and req_bank_i on BA. Refresh drives A and BA zero.
- R4: The following requests are accepted without delay and give a one-cycle err_o pulse with NOP on the pins: an open-row request to an open bank, a read or write to a closed bank, a refresh or mode load while any bank is open, and op code 7.
- R5: A read or write follows the open of its bank by at least T_RCD cycles. A close of a bank, whether explicit or by auto precharge, follows its open by at least T_RAS cycles.
- R6: An open-row command follows the close of that bank by at least T_RP cycles and the previous open of that bank by at least T_RC cycles. It follows an open of any bank by at least T_RRD cycles.
- R7: No command follows a refresh for T_RFC cycles, and none follows a mode load for T_MRD cycles. Refresh and mode load also wait until every bank has finished its precharge.
- R8: A read or write with auto precharge closes the bank. The bank may be opened again no sooner than BURST_LEN/2 + T_RP cycles later. After a write with auto precharge, no read or write is issued for BURST_LEN/2 cycles.
- R9: Every T_REFI cycles a refresh becomes pending and req_ready_o stays low until it is served. The block closes all banks with a close-all command if any bank is open, then issues refresh once all spacing rules allow it.
- R10: A request that is not ready is held by the host and is issued exactly once, in the first cycle in which it becomes legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Request accepted in this cycle when valid |
| req_op_i | input | 3 | Request op code (R2) |
| req_bank_i | input | BANK_W (2) | Target bank |
| req_addr_i | input | ADDR_W (13) | Row, column or mode word |
| req_ap_i | input | 1 | Auto precharge on read or write |
| err_o | output | 1 | One-cycle illegal-request pulse |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | BANK_W (2) | Bank address |
| addr_o | output | ADDR_W (13) | Address pins |

## Verification
Several properties are checked on every cycle by the assertions. An error cycle always shows NOP. Only one source ever drives a command. A bank is opened only while closed and only after its precharge and row-cycle counts have expired. Auto precharge is taken only from an open bank whose active time has run out. Refresh reaches the pins only with every bank closed. The cycle after a mode load is idle, and no column command directly follows a write with auto precharge. The exact number of cycles each request waits can only be shown by the bench scenarios, which compare every cycle against a timestamp model. The same holds for the pin fields, the close-then-refresh sequence when the interval expires with rows open, and the stalling of held requests during it.

// File: rtl/ddr_sched_pkg.sv
package ddr_sched_pkg;
  typedef enum logic [2:0] {
    OP_ACT  = 3'd0,
    OP_RD   = 3'd1,
    OP_WR   = 3'd2,
    OP_PRE  = 3'd3,
    OP_PREA = 3'd4,
    OP_REF  = 3'd5,
    OP_MRS  = 3'd6,
    OP_BAD  = 3'd7
  } op_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PIN_MRS = 4'b0000;
  localparam logic [3:0] PIN_REF = 4'b0001;
  localparam logic [3:0] PIN_PRE = 4'b0010;
  localparam logic [3:0] PIN_ACT = 4'b0011;
  localparam logic [3:0] PIN_WR  = 4'b0100;
  localparam logic [3:0] PIN_RD  = 4'b0101;
  localparam logic [3:0] PIN_NOP = 4'b0111;

  function automatic int unsigned cnt_w(int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction
endpackage

// File: rtl/ddr_down_cnt.sv
module ddr_down_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ddr_bank_state.sv
module ddr_bank_state
  import ddr_sched_pkg::*;
#(
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RAS     = 6,
  parameter int unsigned T_RC      = 9,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned BURST_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic pre_i,
  input  logic ap_i,
  output logic open_o,
  output logic col_ok_o,
  output logic pre_ok_o,
  output logic act_ok_o,
  output logic idle_o
);
  localparam int unsigned W = cnt_w(T_RC + T_RP + BURST_CYC);

  logic open_q;
  logic rcd_z, ras_z, rc_z, rp_z;
  logic rp_load;
  logic [W-1:0] rp_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             open_q <= 1'b0;
    else if (act_i)          open_q <= 1'b1;
    else if (pre_i || ap_i)  open_q <= 1'b0;
  end

  // auto precharge starts once the burst has left the array
  assign rp_load = (pre_i && open_q) || ap_i;
  assign rp_val  = ap_i ? W'(BURST_CYC + T_RP - 1) : W'(T_RP - 1);

  ddr_down_cnt #(.W(W)) u_rcd (.clk_i, .rst_ni, .load_i(act_i), .val_i(W'(T_RCD - 1)), .zero_o(rcd_z));
  ddr_down_cnt #(.W(W)) u_ras (.clk_i, .rst_ni, .load_i(act_i), .val_i(W'(T_RAS - 1)), .zero_o(ras_z));
  ddr_down_cnt #(.W(W)) u_rc  (.clk_i, .rst_ni, .load_i(act_i), .val_i(W'(T_RC - 1)),  .zero_o(rc_z));
  ddr_down_cnt #(.W(W)) u_rp  (.clk_i, .rst_ni, .load_i(rp_load), .val_i(rp_val),     .zero_o(rp_z));

  assign open_o   = open_q;
  assign col_ok_o = open_q && rcd_z;
  assign pre_ok_o = !open_q || ras_z;
  assign act_ok_o = !open_q && rp_z && rc_z;
  assign idle_o   = !open_q && rp_z;

  a_r4_act_only_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> !open_q);
  a_r6_act_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> (rp_z && rc_z));
  a_r5_ap_after_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_i |-> (open_q && ras_z));
endmodule

// File: rtl/ddr_refresh_timer.sv
module ddr_refresh_timer
  import ddr_sched_pkg::*;
#(
  parameter int unsigned T_REFI = 1040
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  output logic pend_o
);
  localparam int unsigned W = cnt_w(T_REFI);

  logic [W-1:0] cnt_q;
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= W'(T_REFI - 1);
      pend_q <= 1'b0;
    end else begin
      if (cnt_q == '0) cnt_q <= W'(T_REFI - 1);
      else             cnt_q <= cnt_q - 1'b1;
      // expiry wins over a completing refresh
      if (cnt_q == '0)  pend_q <= 1'b1;
      else if (done_i)  pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/ddr_cmd_sched.sv
module ddr_cmd_sched
  import ddr_sched_pkg::*;
#(
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned COL_W     = 10,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RAS     = 6,
  parameter int unsigned T_RC      = 9,
  parameter int unsigned T_RRD     = 2,
  parameter int unsigned T_RFC     = 10,
  parameter int unsigned T_MRD     = 2,
  parameter int unsigned T_REFI    = 1040
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_op_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_ap_i,
  output logic              err_o,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [BANK_W-1:0] ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned NB        = 1 << BANK_W;
  localparam int unsigned AP_BIT    = COL_W;
  localparam int unsigned BURST_CYC = BURST_LEN / 2;
  localparam int unsigned W_RRD     = cnt_w(T_RRD);
  localparam int unsigned W_RFC     = cnt_w(T_RFC);
  localparam int unsigned W_MRD     = cnt_w(T_MRD);
  localparam int unsigned W_WAP     = cnt_w(BURST_CYC);

  op_e op;
  logic [NB-1:0] open_v, col_ok_v, pre_ok_v, act_ok_v, idle_v, act_v, pre_v, ap_v;
  logic rrd_z, rfc_z, mrd_z, wap_z, pend;
  logic is_err, tim_ok, glob_ok, host_fire, host_err, ref_prea, ref_go;
  logic [3:0] nxt_cmd, cmd_q;
  logic [BANK_W-1:0] nxt_ba;
  logic [ADDR_W-1:0] nxt_addr;

  assign op = op_e'(req_op_i);

  always_comb begin
    is_err = 1'b0;
    tim_ok = 1'b0;
    unique case (op)
      OP_ACT: begin
        is_err = open_v[req_bank_i];
        tim_ok = act_ok_v[req_bank_i] && rrd_z;
      end
      OP_RD, OP_WR: begin
        is_err = !open_v[req_bank_i];
        tim_ok = col_ok_v[req_bank_i] && wap_z && (!req_ap_i || pre_ok_v[req_bank_i]);
      end
      OP_PRE:  tim_ok = pre_ok_v[req_bank_i];
      OP_PREA: tim_ok = &pre_ok_v;
      OP_REF, OP_MRS: begin
        is_err = |open_v;
        tim_ok = &idle_v;
      end
      default: is_err = 1'b1;
    endcase
  end

  assign glob_ok     = rfc_z && mrd_z;
  assign req_ready_o = !pend && (is_err || (glob_ok && tim_ok));
  assign host_fire   = req_valid_i && req_ready_o && !is_err;
  assign host_err    = req_valid_i && req_ready_o && is_err;
  assign ref_prea    = pend && (|open_v) && glob_ok && (&pre_ok_v);
  assign ref_go      = pend && !(|open_v) && glob_ok && (&idle_v);

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic sel;
    assign sel      = host_fire && (req_bank_i == BANK_W'(g));
    assign act_v[g] = sel && (op == OP_ACT);
    assign ap_v[g]  = sel && (op == OP_RD || op == OP_WR) && req_ap_i;
    assign pre_v[g] = (sel && op == OP_PRE) || (host_fire && op == OP_PREA) || ref_prea;

    ddr_bank_state #(
      .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP), .BURST_CYC(BURST_CYC)
    ) u_bank (
      .clk_i, .rst_ni,
      .act_i(act_v[g]), .pre_i(pre_v[g]), .ap_i(ap_v[g]),
      .open_o(open_v[g]), .col_ok_o(col_ok_v[g]), .pre_ok_o(pre_ok_v[g]),
      .act_ok_o(act_ok_v[g]), .idle_o(idle_v[g])
    );
  end

  ddr_down_cnt #(.W(W_RRD)) u_rrd (.clk_i, .rst_ni, .load_i(|act_v),
    .val_i(W_RRD'(T_RRD - 1)), .zero_o(rrd_z));
  ddr_down_cnt #(.W(W_RFC)) u_rfc (.clk_i, .rst_ni, .load_i(ref_go || (host_fire && op == OP_REF)),
    .val_i(W_RFC'(T_RFC - 1)), .zero_o(rfc_z));
  ddr_down_cnt #(.W(W_MRD)) u_mrd (.clk_i, .rst_ni, .load_i(host_fire && op == OP_MRS),
    .val_i(W_MRD'(T_MRD - 1)), .zero_o(mrd_z));
  ddr_down_cnt #(.W(W_WAP)) u_wap (.clk_i, .rst_ni, .load_i(host_fire && op == OP_WR && req_ap_i),
    .val_i(W_WAP'(BURST_CYC - 1)), .zero_o(wap_z));

  ddr_refresh_timer #(.T_REFI(T_REFI)) u_refi (.clk_i, .rst_ni, .done_i(ref_go), .pend_o(pend));

  always_comb begin
    nxt_cmd  = PIN_NOP;
    nxt_ba   = '0;
    nxt_addr = '0;
    if (ref_prea) begin
      nxt_cmd          = PIN_PRE;
      nxt_addr[AP_BIT] = 1'b1;
    end else if (ref_go) begin
      nxt_cmd = PIN_REF;
    end else if (host_fire) begin
      unique case (op)
        OP_ACT: begin
          nxt_cmd = PIN_ACT; nxt_ba = req_bank_i; nxt_addr = req_addr_i;
        end
        OP_RD, OP_WR: begin
          nxt_cmd                 = (op == OP_RD) ? PIN_RD : PIN_WR;
          nxt_ba                  = req_bank_i;
          nxt_addr[COL_W-1:0]     = req_addr_i[COL_W-1:0];
          nxt_addr[AP_BIT]        = req_ap_i;
        end
        OP_PRE: begin
          nxt_cmd = PIN_PRE; nxt_ba = req_bank_i;
        end
        OP_PREA: begin
          nxt_cmd = PIN_PRE; nxt_addr[AP_BIT] = 1'b1;
        end
        OP_REF: nxt_cmd = PIN_REF;
        OP_MRS: begin
          nxt_cmd = PIN_MRS; nxt_ba = req_bank_i; nxt_addr = req_addr_i;
        end
        default: nxt_cmd = PIN_NOP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= PIN_NOP;
      ba_o   <= '0;
      addr_o <= '0;
      err_o  <= 1'b0;
    end else begin
      cmd_q  <= nxt_cmd;
      ba_o   <= nxt_ba;
      addr_o <= nxt_addr;
      err_o  <= host_err;
    end
  end

  assign {cs_no, ras_no, cas_no, we_no} = cmd_q;

  a_r4_err_shows_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cmd_q == PIN_NOP));
  a_r2_single_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({host_fire, host_err, ref_prea, ref_go}));
  a_r9_refresh_all_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nxt_cmd == PIN_REF) |-> !(|open_v));

  if (T_MRD >= 2) begin : g_mrd_chk
    a_r7_mrd_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_q == PIN_MRS) |=> (cmd_q == PIN_NOP));
  end

  if (BURST_CYC >= 2) begin : g_wap_chk
    a_r8_wap_no_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_q == PIN_WR && addr_o[AP_BIT]) |=> !(cmd_q == PIN_RD || cmd_q == PIN_WR));
  end
endmodule

// File: tb/ddr_cmd_sched_test.sv
module ddr_cmd_sched_test;
  localparam int TRCD = 3, TRP = 3, TRAS = 6, TRC = 9, TRRD = 2, TRFC = 10, TMRD = 2;
  localparam int TREFI = 150, BL = 4, BC = BL / 2;
  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rq_valid = 1'b0;
  logic [2:0] rq_op = '0;
  logic [1:0] rq_bank = '0;
  logic [12:0] rq_addr = '0;
  logic rq_ap = 1'b0;
  logic ready, err, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [12:0] addr;

  always #5 clk = ~clk;

  ddr_cmd_sched #(
    .T_RCD(TRCD), .T_RP(TRP), .T_RAS(TRAS), .T_RC(TRC), .T_RRD(TRRD),
    .T_RFC(TRFC), .T_MRD(TMRD), .T_REFI(TREFI), .BURST_LEN(BL)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(rq_valid), .req_ready_o(ready),
    .req_op_i(rq_op), .req_bank_i(rq_bank), .req_addr_i(rq_addr), .req_ap_i(rq_ap),
    .err_o(err), .cs_no(cs_n), .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n),
    .ba_o(ba), .addr_o(addr)
  );

  int nchecks = 0, nerrs = 0;
  bit finished = 0;

  // timestamp reference model: earliest legal cycle per rule
  int k = 0;
  bit bo[4];
  int rcd_ok[4], ras_ok[4], rc_ok[4], rp_ok[4];
  int rrd_ok = 0, rfc_ok = 0, mrd_ok = 0, wap_ok = 0, ref_due = TREFI;
  bit pend = 0;
  bit m_ready;
  logic [3:0] e_cmd = C_NOP;
  logic [1:0] e_ba = '0;
  logic [12:0] e_addr = '0;
  bit e_err = 0;
  string e_tag = "R1";
  string r_tag = "R10";

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    nchecks++;
    if (!ok) begin
      nerrs++;
      $display("FAIL %s %s at step %0d: got %0h expected %0h", tag, what, k, act, exp);
    end
  endtask

  task automatic model_eval();
    bit glob, any_open, all_pre, all_idle, is_err, tim;
    int b;
    if (k == ref_due) begin
      pend = 1;
      ref_due += TREFI;
    end
    e_cmd = C_NOP; e_ba = '0; e_addr = '0; e_err = 0; e_tag = "R1";
    m_ready = 0;
    glob = (k >= rfc_ok) && (k >= mrd_ok);
    any_open = 0; all_pre = 1; all_idle = 1;
    for (int i = 0; i < 4; i++) begin
      if (bo[i]) any_open = 1;
      if (bo[i] && k < ras_ok[i]) all_pre = 0;
      if (bo[i] || k < rp_ok[i]) all_idle = 0;
    end
    if (pend) begin
      r_tag = "R9";
      if (any_open) begin
        if (glob && all_pre) begin
          e_cmd = C_PRE; e_addr = 13'h400; e_tag = "R9";
          for (int i = 0; i < 4; i++)
            if (bo[i]) begin bo[i] = 0; rp_ok[i] = k + TRP; end
        end
      end else if (glob && all_idle) begin
        e_cmd = C_REF; e_tag = "R9"; rfc_ok = k + TRFC; pend = 0;
      end
      return;
    end
    b = int'(rq_bank);
    is_err = 0; tim = 0;
    case (int'(rq_op))
      0: begin
        r_tag = "R6";
        is_err = bo[b];
        tim = (k >= rp_ok[b]) && (k >= rc_ok[b]) && (k >= rrd_ok);
      end
      1, 2: begin
        r_tag = (rq_op == 3'd2) ? "R8" : "R5";
        is_err = !bo[b];
        tim = (k >= rcd_ok[b]) && (k >= wap_ok) && (!rq_ap || k >= ras_ok[b]);
      end
      3: begin r_tag = "R5"; tim = !bo[b] || (k >= ras_ok[b]); end
      4: begin r_tag = "R5"; tim = all_pre; end
      5, 6: begin r_tag = "R7"; is_err = any_open; tim = all_idle; end
      default: begin r_tag = "R4"; is_err = 1; end
    endcase
    m_ready = is_err || (glob && tim);
    if (!(rq_valid && m_ready)) return;
    if (is_err) begin
      e_err = 1; e_tag = "R4";
      return;
    end
    case (int'(rq_op))
      0: begin
        e_cmd = C_ACT; e_ba = rq_bank; e_addr = rq_addr; e_tag = "R2";
        bo[b] = 1; rcd_ok[b] = k + TRCD; ras_ok[b] = k + TRAS; rc_ok[b] = k + TRC;
        rrd_ok = k + TRRD;
      end
      1, 2: begin
        e_cmd = (rq_op == 3'd1) ? C_RD : C_WR; e_ba = rq_bank; e_tag = "R3";
        e_addr = {2'b00, rq_ap, rq_addr[9:0]};
        if (rq_ap) begin
          bo[b] = 0; rp_ok[b] = k + BC + TRP;
          if (rq_op == 3'd2) wap_ok = k + BC;
        end
      end
      3: begin
        e_cmd = C_PRE; e_ba = rq_bank; e_tag = "R6";
        if (bo[b]) begin bo[b] = 0; rp_ok[b] = k + TRP; end
      end
      4: begin
        e_cmd = C_PRE; e_addr = 13'h400; e_tag = "R3";
        for (int i = 0; i < 4; i++)
          if (bo[i]) begin bo[i] = 0; rp_ok[i] = k + TRP; end
      end
      5: begin e_cmd = C_REF; e_tag = "R7"; rfc_ok = k + TRFC; end
      default: begin
        e_cmd = C_MRS; e_ba = rq_bank; e_addr = rq_addr; e_tag = "R7";
        mrd_ok = k + TMRD;
      end
    endcase
  endtask

  task automatic check_pins(string tag);
    chk({cs_n, ras_n, cas_n, we_n} == e_cmd, tag, "cmd", {cs_n, ras_n, cas_n, we_n}, e_cmd);
    chk(ba == e_ba, tag, "ba", ba, e_ba);
    chk(addr == e_addr, tag, "addr", addr, e_addr);
    chk(err == e_err, tag, "err", err, e_err);
  endtask

  // inputs are set at a falling edge; model evaluated 1 ns later; pins checked at next falling edge
  task automatic step();
    #1;
    model_eval();
    if (rq_valid || pend) chk(ready == m_ready, {r_tag, "/R10"}, "ready", ready, m_ready);
    @(negedge clk);
    check_pins(e_tag);
    k++;
  endtask

  task automatic do_req(int op, int bank, int a, bit ap);
    bit acc = 0;
    rq_valid = 1; rq_op = 3'(op); rq_bank = 2'(bank); rq_addr = 13'(a); rq_ap = ap;
    for (int n = 0; n < 400 && !acc; n++) begin
      step();
      acc = m_ready;
    end
    rq_valid = 0;
  endtask

  task automatic idle(int n);
    rq_valid = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      bo[i] = 0; rcd_ok[i] = 0; ras_ok[i] = 0; rc_ok[i] = 0; rp_ok[i] = 0;
    end
    repeat (3) @(negedge clk);
    e_cmd = C_NOP;
    check_pins("R1");  // reset state
    rst_n = 1'b1;
    idle(2);
    // R7: mode load then an immediate open must wait T_MRD
    do_req(6, 1, 13'h031, 0);
    do_req(0, 0, 13'h1ABC, 0);
    // R5: read waits T_RCD
    do_req(1, 0, 13'h005, 0);
    // R6: different-bank open waits T_RRD
    do_req(0, 1, 13'h0777, 0);
    // R8: write with auto precharge, then read is held, then reopen waits burst+T_RP and T_RC
    do_req(2, 1, 13'h3FF, 1);
    do_req(1, 0, 13'h012, 0);
    do_req(0, 1, 13'h0042, 0);
    // R4: illegal requests
    do_req(1, 2, 13'h001, 0);
    do_req(0, 0, 13'h0001, 0);
    do_req(5, 0, 0, 0);
    do_req(6, 0, 0, 0);
    do_req(7, 3, 0, 0);
    // R6 close then reopen, R3 close-all, R7 refresh then mode load
    do_req(3, 0, 0, 0);
    do_req(0, 0, 13'h0100, 0);
    do_req(4, 0, 0, 0);
    do_req(5, 0, 0, 0);
    do_req(6, 2, 13'h1555, 0);
    // R9: leave a row open across the refresh interval, with a request held meanwhile
    do_req(0, 3, 13'h0ABC, 0);
    idle(TREFI);
    do_req(1, 3, 13'h2AA, 0);
    // mixed traffic
    for (int it = 0; it < 3000; it++) begin
      int op = int'($urandom_range(0, 7));
      if ($urandom_range(0, 3) != 0 && op > 3) op = int'($urandom_range(0, 3));
      do_req(op, int'($urandom_range(0, 3)), int'($urandom_range(0, 8191)), 1'($urandom_range(0, 1)));
      idle(int'($urandom_range(0, 3)));
    end
    idle(5);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
      $finish;
    end
  end

  initial begin
    #1_800_000;
    if (!finished) begin
      finished = 1;
      nerrs++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
      $finish;
    end
  end
endmodule